// File: doc/BRIEF.md
# Global Halt Pulse Generator

This block joins a debug-halt source bus to a debug-halt broadcast line. All boards share an active-low event line, `evt_n`, which any processor may pull low when it stops. When the block sees that line fall, it drives a bounded low pulse on a separate broadcast line, `halt_n`. That pulse halts every processor on every board. Each emulation pin gets its own instance.

Keeping the input and the output on separate nets matters. The shared open-collector line cannot then hold itself low through its own feedback. The pulse is also bounded: it is long enough to cover the halt request but ends well before software releases the pins.

Everything runs on a fast reference clock `clk`. The test clock `tck` enters as a plain input and is synchronised. The pulse ends on the `PULSE_TCK`-th synchronised test-clock rising edge. If the test clock has stopped, a reference-clock timeout of `REF_TIMEOUT` cycles ends it instead. An external-count enable, `ext_hold`, overrides the block and keeps the broadcast line high.

Top module: `global_halt_pulser`

## Requirements
- R1: During reset, and after reset, `halt_n` is high. If `evt_n` has been low since reset and has never been seen high, no pulse is produced.
- R2: A high-to-low transition on `evt_n`, with `ext_hold` low, drives `halt_n` low. The low level appears after the third rising edge of `clk` that follows the input change (two synchroniser flops, then the pulse flop).
- R3: If `evt_n` stays low after a pulse, no further pulse is produced.
- R4: With the test clock running, the pulse ends on the `PULSE_TCK`-th synchronised rising edge of `tck` after it starts. Its width therefore covers at least `PULSE_TCK-1` full test-clock periods.
- R5: The pulse never lasts more than `REF_TIMEOUT` `clk` cycles. With `tck` stopped, it lasts exactly `REF_TIMEOUT` cycles.
- R6: While `ext_hold` is high, `halt_n` is high whatever `evt_n` does. A falling edge seen while `ext_hold` is high does not start a pulse, even after `ext_hold` is released.
- R7: Raising `ext_hold` during a pulse returns `halt_n` high in the same cycle. The pulse does not resume when `ext_hold` falls.
- R8: Once `evt_n` has been seen high after a pulse, the next falling edge starts a new pulse. Between two pulses `halt_n` stays high for at least two cycles.
- R9: Transitions of `evt_n` that occur while a pulse is active are ignored. A low level that is still present when the pulse ends does not retrigger it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tck | input | 1 | Test clock, sampled through a synchroniser |
| evt_n | input | 1 | Shared active-low halt event line from all boards |
| ext_hold | input | 1 | External-count enable; forces the output high |
| halt_n | output | 1 | Active-low halt broadcast pulse to all boards |

## Verification
On every cycle, the assertions check four things:
- the upper bound on pulse length;
- that `ext_hold` keeps the output high on the following cycle;
- that a pulse only starts after the synchronised event line was seen low;
- that at least two high cycles separate consecutive pulses.

Other behaviour depends on history and can only be shown by directed scenarios:
- the edge-only trigger, and the re-arm that needs a high level first;
- the exact three-cycle start latency;
- the pulse width measured against a running or a stopped test clock;
- the loss of an edge that arrives while `ext_hold` is high.

// File: rtl/global_halt_pulser.sv
module global_halt_pulser #(
  parameter int PULSE_TCK   = 2,
  parameter int REF_TIMEOUT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck,
  input  logic evt_n,
  input  logic ext_hold,
  output logic halt_n
);
  localparam int TW = $clog2(PULSE_TCK + 1);
  localparam int RW = $clog2(REF_TIMEOUT + 1);

  logic [1:0]    evt_sync;
  logic          evt_prev;
  logic [2:0]    tck_sync;
  logic          pulsing;
  logic          armed;
  logic [TW-1:0] tcnt;
  logic [RW-1:0] rcnt;

  wire evt_fall = evt_prev & ~evt_sync[1];
  wire tck_rise = tck_sync[1] & ~tck_sync[2];
  wire tck_done = tck_rise && (tcnt == TW'(PULSE_TCK - 1));
  wire ref_done = (rcnt == RW'(REF_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_sync <= '0;
      evt_prev <= 1'b0;
      tck_sync <= '0;
    end else begin
      evt_sync <= {evt_sync[0], evt_n};
      evt_prev <= evt_sync[1];
      tck_sync <= {tck_sync[1:0], tck};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulsing <= 1'b0;
      armed   <= 1'b0;
      tcnt    <= '0;
      rcnt    <= '0;
    end else if (pulsing) begin
      if (ext_hold || tck_done || ref_done) begin
        pulsing <= 1'b0;
      end else begin
        rcnt <= rcnt + 1'b1;
        if (tck_rise) tcnt <= tcnt + 1'b1;
      end
    end else if (armed && evt_fall && !ext_hold) begin
      pulsing <= 1'b1;
      armed   <= 1'b0;
      tcnt    <= '0;
      rcnt    <= '0;
    end else if (evt_sync[1]) begin
      armed <= 1'b1;
    end
  end

  assign halt_n = ~pulsing | ext_hold;

  logic [RW:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)       low_run <= '0;
    else if (!halt_n) low_run <= low_run + 1'b1;
    else              low_run <= '0;
  end

  assert_pulse_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= (RW+1)'(REF_TIMEOUT));

  assert_hold_keeps_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hold |=> halt_n);

  assert_start_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_n) |-> $past(!evt_sync[1]));

  assert_gap_between_pulses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_n) |=> halt_n);
endmodule

// File: tb/global_halt_pulser_tb.sv
module global_halt_pulser_tb;
  localparam int PT = 2;
  localparam int TO = 40;
  localparam int TCK_HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck = 1'b0;
  logic evt_n = 1'b0;
  logic ext_hold = 1'b0;
  logic halt_n;
  logic tck_run = 1'b1;
  int   tdiv = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  global_halt_pulser #(.PULSE_TCK(PT), .REF_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .tck(tck), .evt_n(evt_n),
    .ext_hold(ext_hold), .halt_n(halt_n));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tck_run) begin
      if (tdiv == TCK_HALF - 1) begin
        tdiv <= 0;
        tck <= ~tck;
      end else begin
        tdiv <= tdiv + 1;
      end
    end
  end

  function automatic bit in_range(int v, int lo, int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_lows(int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!halt_n) lows++;
    end
  endtask

  task automatic fall_and_measure(output int dly, output int wid);
    evt_n = 1'b0;
    dly = 0;
    while (halt_n && dly < 60) begin
      @(negedge clk);
      dly++;
    end
    wid = 0;
    while (!halt_n && wid < 1000) begin
      @(negedge clk);
      wid++;
    end
  endtask

  initial begin
    int dly, wid, lows, run;
    void'($urandom(32'd4242));
    cycles(3);
    check(halt_n == 1'b1, "R1", halt_n, 1);
    rst_n = 1'b1;
    count_lows(30, lows);
    check(lows == 0, "R1", lows, 0);

    evt_n = 1'b1;
    cycles(10);
    fall_and_measure(dly, wid);
    check(dly == 3, "R2", dly, 3);
    check(in_range(wid, (PT-1)*2*TCK_HALF, PT*2*TCK_HALF + 2), "R4", wid, PT*2*TCK_HALF);
    count_lows(60, lows);
    check(lows == 0, "R3", lows, 0);

    evt_n = 1'b1;
    cycles(10);
    fall_and_measure(dly, wid);
    check(dly == 3, "R8", dly, 3);

    evt_n = 1'b1;
    cycles(10);
    evt_n = 1'b0;
    cycles(3);
    check(halt_n == 1'b0, "R9", halt_n, 0);
    cycles(1);
    evt_n = 1'b1;
    cycles(2);
    evt_n = 1'b0;
    wid = 0;
    while (!halt_n && wid < 1000) begin
      @(negedge clk);
      wid++;
    end
    count_lows(60, lows);
    check(lows == 0, "R9", lows, 0);

    evt_n = 1'b1;
    ext_hold = 1'b1;
    cycles(10);
    evt_n = 1'b0;
    count_lows(20, lows);
    check(lows == 0, "R6", lows, 0);
    ext_hold = 1'b0;
    count_lows(30, lows);
    check(lows == 0, "R6", lows, 0);

    evt_n = 1'b1;
    cycles(10);
    evt_n = 1'b0;
    cycles(4);
    check(halt_n == 1'b0, "R7", halt_n, 0);
    ext_hold = 1'b1;
    #1;
    check(halt_n == 1'b1, "R7", halt_n, 1);
    cycles(2);
    ext_hold = 1'b0;
    count_lows(30, lows);
    check(lows == 0, "R7", lows, 0);

    tck_run = 1'b0;
    evt_n = 1'b1;
    cycles(10);
    fall_and_measure(dly, wid);
    check(dly == 3, "R2", dly, 3);
    check(wid == TO, "R5", wid, TO);
    tck_run = 1'b1;

    run = 0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) evt_n = ~evt_n;
      if ($urandom_range(0, 49) == 0) ext_hold = ~ext_hold;
      @(negedge clk);
      if (ext_hold) check(halt_n == 1'b1, "R6", halt_n, 1);
      run = halt_n ? 0 : run + 1;
      if (!halt_n) check(run <= TO, "R5", run, TO);
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule